// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks the two source operands for the execute stage of a five-stage in-order RISC-V pipeline. The execute stage can read a register whose new value has not yet reached the register file. For each source operand the unit compares that operand's register number with the destination register of two producers: the instruction now in the memory stage and the instruction now in write-back. The operand is then taken from one of three places. These are the register-file read value, the ALU result held in the EX/MEM register, or the write-back mux output held in MEM/WB.

The selection is purely combinational. Each operand has its own 2-bit select and its own 3-to-1 multiplexer. The forwarded operands feed every consumer in the execute stage: both ALU inputs, the store write data and both inputs of the branch comparator. The unit sits inside the execute stage between the pipeline registers. It passes data through directly with no valid/ready handshake, because the surrounding pipeline registers already carry each instruction's timing. Stall and flush control lie outside this block.

Top module: `fwd_unit`

## Requirements
- R1: The select of an operand is 2 (memory-stage ALU result) when its source register is nonzero, equals the memory-stage destination, and the memory-stage write flag is 1. The operand then equals the memory-stage ALU result.
- R2: The select is 1 (write-back value) when there is no memory-stage match, the source register is nonzero and equals the write-back destination, and the write-back write flag is 1. The operand then equals the write-back value.
- R3: In every other case the select is 0 and the operand equals the register-file read value for that source.
- R4: When both producers match the same source and both write, the memory-stage result wins (select 2).
- R5: A producer whose write flag is 0 is never a forwarding source, even when its destination equals the source register.
- R6: A source register of 0 is never forwarded. The select is 0 and the operand is the register-file value.
- R7: The second operand follows the same rule on its own, driven by the second source register and the second read value.
- R8: The first ALU input and the first comparator input both equal the forwarded first operand. The second ALU input, the store write data and the second comparator input all equal the forwarded second operand.
- R9: A select of 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src1 | input | 5 | First source register of the instruction in execute |
| ex_src2 | input | 5 | Second source register of the instruction in execute |
| rf_val1 | input | 64 | Register-file read value for the first source |
| rf_val2 | input | 64 | Register-file read value for the second source |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| mem_alu_res | input | 64 | ALU result held in the EX/MEM register |
| wb_dst | input | 5 | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes the register file |
| wb_value | input | 64 | Write-back mux output held in MEM/WB |
| op_a_sel | output | 2 | Select for the first operand: 0 register file, 1 write-back, 2 memory stage |
| op_b_sel | output | 2 | Select for the second operand, same encoding |
| alu_in_a | output | 64 | First ALU input |
| alu_in_b | output | 64 | Second ALU input |
| store_wdata | output | 64 | Store write data |
| cmp_lhs | output | 64 | First branch comparator input |
| cmp_rhs | output | 64 | Second branch comparator input |

## Verification
The bench sweeps every combination of source register, memory-stage destination and write-back destination over registers 0 to 7, together with all four settings of the two write flags. The sweep covers cases with no match, a match in one stage only, a match in both stages, a match with the write flag clear, and register 0 matching everything. The second source is derived from the first, so the two operands often land in different cases and any cross-coupling between them shows up. The data values change on every step and differ between the three sources, so a wrong multiplexer input can never look correct by accident. Directed cases set up the two-stage priority, a producer with its write flag clear, and register 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned REG_W = 5;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned RW = REG_W
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  always_comb begin
    src_live = (src != '0);
    hit_mem  = src_live && mem_wen && (src == mem_dst);
    hit_wb   = src_live && wb_wen  && (src == wb_dst);
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  always_comb begin
    AST_ZERO_NOT_FORWARDED: assert ((src != '0) || (sel == SRC_RF)) else $error("x0 forwarded"); // R6
    AST_MEM_NEEDS_WRITE: assert ((sel != SRC_MEM) || mem_wen) else $error("mem source without write"); // R5
    AST_WB_NEEDS_WRITE: assert ((sel != SRC_WB) || wb_wen) else $error("wb source without write"); // R5
    AST_SEL_ENCODING: assert (sel != 2'd3) else $error("select 3 produced"); // R9
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  fwd_sel_e      sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] out
);
  always_comb begin
    unique case (sel)
      SRC_MEM: out = mem_val;
      SRC_WB:  out = wb_val;
      default: out = rf_val;
    endcase
  end

  always_comb begin
    AST_MEM_PATH: assert ((sel != SRC_MEM) || (out == mem_val)) else $error("mem path wrong"); // R1
    AST_WB_PATH: assert ((sel != SRC_WB) || (out == wb_val)) else $error("wb path wrong"); // R2
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DW = XLEN,
  parameter int unsigned RW = REG_W
) (
  input  logic [RW-1:0] ex_src1,
  input  logic [RW-1:0] ex_src2,
  input  logic [DW-1:0] rf_val1,
  input  logic [DW-1:0] rf_val2,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [DW-1:0] mem_alu_res,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_value,
  output logic [1:0]    op_a_sel,
  output logic [1:0]    op_b_sel,
  output logic [DW-1:0] alu_in_a,
  output logic [DW-1:0] alu_in_b,
  output logic [DW-1:0] store_wdata,
  output logic [DW-1:0] cmp_lhs,
  output logic [DW-1:0] cmp_rhs
);
  localparam int unsigned NUM_SRC = 2;

  logic [RW-1:0] src_num [NUM_SRC];
  logic [DW-1:0] rf_in   [NUM_SRC];
  logic [DW-1:0] opnd    [NUM_SRC];
  fwd_sel_e      sel     [NUM_SRC];

  assign src_num[0] = ex_src1;
  assign src_num[1] = ex_src2;
  assign rf_in[0]   = rf_val1;
  assign rf_in[1]   = rf_val2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_match #(.RW(RW)) u_match (
      .src     (src_num[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .sel     (sel[g])
    );

    fwd_mux #(.DW(DW)) u_mux (
      .sel     (sel[g]),
      .rf_val  (rf_in[g]),
      .mem_val (mem_alu_res),
      .wb_val  (wb_value),
      .out     (opnd[g])
    );

    always_comb begin
      AST_NEAREST_WINS: assert (!((src_num[g] != '0) && mem_wen && wb_wen &&
                                  (src_num[g] == mem_dst) && (mem_dst == wb_dst))
                                || (opnd[g] == mem_alu_res)) else $error("priority wrong"); // R4
      AST_NO_MATCH_RF: assert (((src_num[g] == mem_dst) && mem_wen) ||
                               ((src_num[g] == wb_dst) && wb_wen) ||
                               (opnd[g] == rf_in[g])) else $error("spurious forward"); // R3
    end
  end

  assign op_a_sel    = sel[0];
  assign op_b_sel    = sel[1];
  assign alu_in_a    = opnd[0];
  assign cmp_lhs     = opnd[0];
  assign alu_in_b    = opnd[1];
  assign store_wdata = opnd[1];
  assign cmp_rhs     = opnd[1];
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  ex_src1, ex_src2, mem_dst, wb_dst;
  logic        mem_wen, wb_wen;
  logic [63:0] rf_val1, rf_val2, mem_alu_res, wb_value;
  logic [1:0]  op_a_sel, op_b_sel;
  logic [63:0] alu_in_a, alu_in_b, store_wdata, cmp_lhs, cmp_rhs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  fwd_unit u_fwd_unit (
    .ex_src1(ex_src1), .ex_src2(ex_src2), .rf_val1(rf_val1), .rf_val2(rf_val2),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_alu_res(mem_alu_res),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_value(wb_value),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .alu_in_a(alu_in_a), .alu_in_b(alu_in_b),
    .store_wdata(store_wdata), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic [4:0] md,
                                         input logic mw, input logic [4:0] wd, input logic ww);
    if (s == 5'd0) return 2'd0;
    if (mw && (s == md)) return 2'd2;
    if (ww && (s == wd)) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string tag_for(input logic [4:0] s, input logic [4:0] md,
                                    input logic mw, input logic [4:0] wd, input logic ww);
    if (s == 5'd0) return "R6";
    if (mw && s == md && ww && s == wd) return "R4";
    if (mw && s == md) return "R1";
    if (ww && s == wd) return "R2";
    if ((s == md && !mw) || (s == wd && !ww)) return "R5";
    return "R3";
  endfunction

  function automatic logic [63:0] pick(input logic [1:0] sl, input logic [63:0] rf);
    case (sl)
      2'd2:    return mem_alu_res;
      2'd1:    return wb_value;
      default: return rf;
    endcase
  endfunction

  task automatic verify();
    logic [1:0] ea, eb;
    logic [63:0] va, vb;
    ea = ref_sel(ex_src1, mem_dst, mem_wen, wb_dst, wb_wen);
    eb = ref_sel(ex_src2, mem_dst, mem_wen, wb_dst, wb_wen);
    va = pick(ea, rf_val1);
    vb = pick(eb, rf_val2);
    check({tag_for(ex_src1, mem_dst, mem_wen, wb_dst, wb_wen), " sel a"}, 64'(op_a_sel), 64'(ea));
    check({tag_for(ex_src1, mem_dst, mem_wen, wb_dst, wb_wen), " alu a"}, alu_in_a, va);
    check({"R7 ", tag_for(ex_src2, mem_dst, mem_wen, wb_dst, wb_wen), " sel b"}, 64'(op_b_sel), 64'(eb));
    check("R7 alu b", alu_in_b, vb);
    check("R8 store", store_wdata, vb);
    check("R8 cmp lhs", cmp_lhs, va);
    check("R8 cmp rhs", cmp_rhs, vb);
    check("R9 sel a not 3", 64'(op_a_sel == 2'd3), 64'd0);
  endtask

  task automatic apply(input logic [4:0] s1, input logic [4:0] s2, input logic [4:0] md,
                       input logic mw, input logic [4:0] wd, input logic ww, input int seed);
    @(negedge clk);
    ex_src1 = s1; ex_src2 = s2; mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
    rf_val1     = {32'hA1A1_0000, 32'(seed)};
    rf_val2     = {32'hA2A2_0000, 32'(seed)};
    mem_alu_res = {32'hC0DE_0000, 32'(seed)};
    wb_value    = {32'hB0B0_0000, 32'(seed)};
    #1;
    verify();
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ex_src1 = '0; ex_src2 = '0; mem_dst = '0; wb_dst = '0;
    mem_wen = 1'b0; wb_wen = 1'b0;
    rf_val1 = 64'h1; rf_val2 = 64'h2; mem_alu_res = 64'h3; wb_value = 64'h4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 idle sel a", 64'(op_a_sel), 64'd0);
    check("R3 idle alu a", alu_in_a, 64'h1);
    check("R3 idle store", store_wdata, 64'h2);

    // R4: both stages target x3 and both write; memory-stage value must win
    apply(5'd3, 5'd3, 5'd3, 1'b1, 5'd3, 1'b1, 1000);
    check("R4 both match", alu_in_a, {32'hC0DE_0000, 32'd1000});
    // R5: memory stage matches but does not write; write-back used
    apply(5'd4, 5'd4, 5'd4, 1'b0, 5'd4, 1'b1, 1001);
    check("R5 mem no write", alu_in_b, {32'hB0B0_0000, 32'd1001});
    // R5: neither writes
    apply(5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 1002);
    check("R5 no writer", cmp_lhs, {32'hA1A1_0000, 32'd1002});
    // R6: x0 with everything matching
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1003);
    check("R6 x0", alu_in_a, {32'hA1A1_0000, 32'd1003});
    // R7: independent operands, a from mem, b from wb
    apply(5'd5, 5'd31, 5'd5, 1'b1, 5'd31, 1'b1, 1004);
    check("R7 split", store_wdata, {32'hB0B0_0000, 32'd1004});

    for (int s = 0; s < 8; s++)
      for (int md = 0; md < 8; md++)
        for (int wd = 0; wd < 8; wd++)
          for (int f = 0; f < 4; f++)
            apply(5'(s), 5'((s + md) % 8), 5'(md), f[0], 5'(wd), f[1],
                  ((s * 8 + md) * 8 + wd) * 4 + f);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule